// File: doc/BRIEF.md
# Timestamped Single-Port Memory Request Arbiter

This block sits in front of a data memory that takes at most one request per clock. Two independent pipeline stages feed it. The execute stage sends loads and the commit stage sends stores, and both can offer a request in the same cycle. Every accepted request is tagged with a value from an internal arrival counter. Loads wait in one queue and stores wait in another. Each cycle, a selector compares the stamps at the two queue heads and sends the older request to the memory port through a registered request stage. When the two stamps are equal, the store goes first.

Only loads return data. The block keeps a response buffer with one slot for every load it may have outstanding. A credit count keeps the number of loads in flight plus buffered responses within that buffer, so the memory's response input needs no back-pressure. Responses leave through a valid/ready output in the order the loads were issued. The stamp counter has two more bits than the combined queue depth needs. Counter wraparound therefore never makes a newer entry look older than a queued one.

Top module: `mem_req_arbiter`

## Requirements
- R1: After synchronous reset, mem_req_valid and rsp_valid are low, and ld_ready and st_ready are high.
- R2: Every accepted request appears on the memory port exactly once, with its own address. A store appears with mem_req_write=1 and its data. A load appears with mem_req_write=0.
- R3: A request accepted in an earlier cycle reaches the memory port before any request accepted in a later cycle.
- R4: When a load and a store are accepted in the same cycle, the store reaches the memory port first.
- R5: At most one request is presented per cycle. While mem_req_valid is high and mem_req_ready is low, mem_req_valid, mem_req_write, mem_req_addr and mem_req_wdata hold their values.
- R6: ld_ready is low when the load queue is full. With mem_req_ready held low, exactly LQ_DEPTH+1 loads are accepted: the queue plus the one-entry request stage.
- R7: st_ready is low when the store queue is full. With mem_req_ready held low, exactly SQ_DEPTH+1 stores are accepted.
- R8: Load data taken from mem_rsp_data is returned on rsp_data in load issue order. rsp_valid and rsp_data hold while rsp_ready is low.
- R9: Loads issued to memory, plus responses not yet taken, never exceed RSP_DEPTH. With rsp_ready low, exactly RSP_DEPTH loads reach the memory port, and RSP_DEPTH+LQ_DEPTH loads are accepted.
- R10: Ordering stays correct over long runs in which the stamp counter wraps many times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_valid | input | 1 | Load request offered by execute |
| ld_ready | output | 1 | Load queue can take an entry |
| ld_addr | input | AW | Load address |
| st_valid | input | 1 | Store request offered by commit |
| st_ready | output | 1 | Store queue can take an entry |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| mem_req_valid | output | 1 | Request to memory valid |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_req_write | output | 1 | 1 = store, 0 = load |
| mem_req_addr | output | AW | Request address |
| mem_req_wdata | output | DW | Store data (zero for loads) |
| mem_rsp_valid | input | 1 | Memory returns load data, in request order |
| mem_rsp_data | input | DW | Returned load data |
| rsp_valid | output | 1 | Load response available |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_data | output | DW | Load response data |

## Verification
The main function is tried with simultaneous load/store arrivals, with interleaved single arrivals while the port is stalled, and with random traffic. The simultaneous arrivals separate the store-first tie rule from plain arrival order. The interleaved arrivals show that a stamp from an earlier cycle beats a later one whatever the request kind. The random traffic is swept over a grid of memory-ready and response-ready duty cycles. It mixes back-pressure from both ends with counter wraparound, and a scoreboard compares every request and response against the order the bench builds from the handshakes it observes. Fill runs against a stalled memory, and against a stalled response consumer, count accepted requests to tell the queue limits apart from the response credit limit.

// File: rtl/mem_arb_pkg.sv
package mem_arb_pkg;

  typedef enum logic {
    KIND_LOAD  = 1'b0,
    KIND_STORE = 1'b1
  } req_kind_e;

  // Extra stamp bits beyond what the combined queue depth needs, so the
  // signed difference of any two queued stamps never wraps.
  localparam int STAMP_GUARD_BITS = 2;

endpackage

// File: rtl/arb_fifo.sv
module arb_fifo #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] din,
  input  logic             pop,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty
);

  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST_IDX = PW'(DEPTH - 1);
  localparam logic [CW-1:0] CAP      = CW'(DEPTH);

  logic [WIDTH-1:0] store_mem [DEPTH];
  logic [PW-1:0]    wr_idx, rd_idx;
  logic [CW-1:0]    fill;
  logic             do_push, do_pop;

  assign full    = (fill == CAP);
  assign empty   = (fill == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = store_mem[rd_idx];

  always_ff @(posedge clk) begin
    if (do_push) store_mem[wr_idx] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_idx <= '0;
      rd_idx <= '0;
      fill   <= '0;
    end else begin
      if (do_push) wr_idx <= (wr_idx == LAST_IDX) ? '0 : wr_idx + 1'b1;
      if (do_pop)  rd_idx <= (rd_idx == LAST_IDX) ? '0 : rd_idx + 1'b1;
      case ({do_push, do_pop})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
    end
  end

endmodule

// File: rtl/stamp_counter.sv
module stamp_counter #(
  parameter int TS_W = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            adv,
  output logic [TS_W-1:0] stamp
);

  always_ff @(posedge clk) begin
    if (rst)      stamp <= '0;
    else if (adv) stamp <= stamp + 1'b1;
  end

endmodule

// File: rtl/order_pick.sv
module order_pick #(
  parameter int TS_W = 4
) (
  input  logic            ld_avail,
  input  logic [TS_W-1:0] ld_ts,
  input  logic            st_avail,
  input  logic [TS_W-1:0] st_ts,
  output logic            pick_any,
  output logic            pick_store
);

  logic [TS_W-1:0] gap;
  logic            load_first;

  // Load strictly older when (ld - st) is negative in modular arithmetic;
  // equal stamps leave load_first low, so the store wins the tie.
  assign gap        = ld_ts - st_ts;
  assign load_first = gap[TS_W-1];
  assign pick_any   = ld_avail || st_avail;
  assign pick_store = st_avail && (!ld_avail || !load_first);

endmodule

// File: rtl/mem_req_arbiter.sv
module mem_req_arbiter
  import mem_arb_pkg::*;
#(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int LQ_DEPTH  = 8,
  parameter int SQ_DEPTH  = 8,
  parameter int RSP_DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [AW-1:0] ld_addr,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_write,
  output logic [AW-1:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic          mem_rsp_valid,
  input  logic [DW-1:0] mem_rsp_data,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data
);

  localparam int TS_W = $clog2(LQ_DEPTH + SQ_DEPTH) + STAMP_GUARD_BITS;
  localparam int LQ_W = TS_W + AW;
  localparam int SQ_W = TS_W + AW + DW;
  localparam int CRW  = $clog2(RSP_DEPTH + 1);
  localparam logic [CRW-1:0] CREDIT_MAX = CRW'(RSP_DEPTH);

  // Arrival stamping
  logic [TS_W-1:0] cur_ts;
  logic            ld_fire, st_fire;

  assign ld_fire = ld_valid && ld_ready;
  assign st_fire = st_valid && st_ready;

  stamp_counter #(.TS_W(TS_W)) u_stamp (
    .clk   (clk),
    .rst   (rst),
    .adv   (ld_fire || st_fire),
    .stamp (cur_ts)
  );

  // Per-source queues
  logic            lq_full, lq_empty, sq_full, sq_empty;
  logic [LQ_W-1:0] lq_dout;
  logic [SQ_W-1:0] sq_dout;
  logic            issue, issue_store;

  assign ld_ready = !lq_full;
  assign st_ready = !sq_full;

  arb_fifo #(.WIDTH(LQ_W), .DEPTH(LQ_DEPTH)) u_load_q (
    .clk   (clk),
    .rst   (rst),
    .push  (ld_fire),
    .din   ({cur_ts, ld_addr}),
    .pop   (issue && !issue_store),
    .dout  (lq_dout),
    .full  (lq_full),
    .empty (lq_empty)
  );

  arb_fifo #(.WIDTH(SQ_W), .DEPTH(SQ_DEPTH)) u_store_q (
    .clk   (clk),
    .rst   (rst),
    .push  (st_fire),
    .din   ({cur_ts, st_addr, st_data}),
    .pop   (issue && issue_store),
    .dout  (sq_dout),
    .full  (sq_full),
    .empty (sq_empty)
  );

  logic [TS_W-1:0] lq_ts, sq_ts, issue_ts;
  logic [AW-1:0]   lq_addr, sq_addr;
  logic [DW-1:0]   sq_data;

  assign lq_ts   = lq_dout[LQ_W-1 -: TS_W];
  assign lq_addr = lq_dout[AW-1:0];
  assign sq_ts   = sq_dout[SQ_W-1 -: TS_W];
  assign sq_addr = sq_dout[AW+DW-1 -: AW];
  assign sq_data = sq_dout[DW-1:0];

  // Ordering
  logic pick_any, pick_store;

  order_pick #(.TS_W(TS_W)) u_pick (
    .ld_avail   (!lq_empty),
    .ld_ts      (lq_ts),
    .st_avail   (!sq_empty),
    .st_ts      (sq_ts),
    .pick_any   (pick_any),
    .pick_store (pick_store)
  );

  // Response credit: loads sent plus responses still buffered
  logic [CRW-1:0] credit_cnt;
  logic           credit_ok, slot_free, rsp_take;

  assign credit_ok   = (credit_cnt < CREDIT_MAX);
  assign slot_free   = !mem_req_valid || mem_req_ready;
  assign issue       = slot_free && pick_any && (pick_store || credit_ok);
  assign issue_store = pick_store;
  assign issue_ts    = pick_store ? sq_ts : lq_ts;
  assign rsp_take    = rsp_valid && rsp_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      credit_cnt <= '0;
    end else begin
      case ({issue && !issue_store, rsp_take})
        2'b10:   credit_cnt <= credit_cnt + 1'b1;
        2'b01:   credit_cnt <= credit_cnt - 1'b1;
        default: credit_cnt <= credit_cnt;
      endcase
    end
  end

  // Registered request stage
  req_kind_e     req_kind;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          req_v;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_v     <= 1'b0;
      req_kind  <= KIND_LOAD;
      req_addr  <= '0;
      req_wdata <= '0;
    end else if (slot_free) begin
      req_v <= issue;
      if (issue) begin
        req_kind  <= issue_store ? KIND_STORE : KIND_LOAD;
        req_addr  <= issue_store ? sq_addr : lq_addr;
        req_wdata <= issue_store ? sq_data : '0;
      end
    end
  end

  assign mem_req_valid = req_v;
  assign mem_req_write = (req_kind == KIND_STORE);
  assign mem_req_addr  = req_addr;
  assign mem_req_wdata = req_wdata;

  // In-order load responses
  logic rsp_empty, rsp_full;

  arb_fifo #(.WIDTH(DW), .DEPTH(RSP_DEPTH)) u_rsp_q (
    .clk   (clk),
    .rst   (rst),
    .push  (mem_rsp_valid),
    .din   (mem_rsp_data),
    .pop   (rsp_take),
    .dout  (rsp_data),
    .full  (rsp_full),
    .empty (rsp_empty)
  );

  assign rsp_valid = !rsp_empty;

endmodule

// File: rtl/mem_arb_checks.sv
module mem_arb_checks #(
  parameter int AW        = 32,
  parameter int DW        = 32,
  parameter int TS_W      = 4,
  parameter int RSP_DEPTH = 8
) (
  input logic            clk,
  input logic            rst,
  input logic            mem_req_valid,
  input logic            mem_req_ready,
  input logic            mem_req_write,
  input logic [AW-1:0]   mem_req_addr,
  input logic [DW-1:0]   mem_req_wdata,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [DW-1:0]   rsp_data,
  input logic            issue,
  input logic            issue_store,
  input logic [TS_W-1:0] issue_ts,
  input logic [$clog2(RSP_DEPTH+1)-1:0] credit_cnt
);

  logic            have_last, last_store;
  logic [TS_W-1:0] last_ts, step_gap;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_last  <= 1'b0;
      last_store <= 1'b0;
      last_ts    <= '0;
    end else if (issue) begin
      have_last  <= 1'b1;
      last_store <= issue_store;
      last_ts    <= issue_ts;
    end
  end

  assign step_gap = issue_ts - last_ts;

  // R5: request stage holds while stalled
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_write) && $stable(mem_req_addr) && $stable(mem_req_wdata)));

  // R8: response holds while not taken
  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)));

  // R3: issued stamps never go backwards
  a_r3_stamp_order: assert property (@(posedge clk) disable iff (rst)
    (issue && have_last) |-> !step_gap[TS_W-1]);

  // R4: a store never follows a load of the same stamp
  a_r4_store_first: assert property (@(posedge clk) disable iff (rst)
    (issue && have_last && !last_store && issue_store) |-> (issue_ts != last_ts));

  // R9: credit bound
  always @(posedge clk) begin
    if (!rst) begin
      a_r9_credit_bound: assert (int'(credit_cnt) <= RSP_DEPTH);
    end
  end

endmodule

bind mem_req_arbiter mem_arb_checks #(
  .AW(AW), .DW(DW), .TS_W(TS_W), .RSP_DEPTH(RSP_DEPTH)
) u_checks (
  .clk           (clk),
  .rst           (rst),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_write (mem_req_write),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_data      (rsp_data),
  .issue         (issue),
  .issue_store   (issue_store),
  .issue_ts      (issue_ts),
  .credit_cnt    (credit_cnt)
);

// File: tb/mem_req_arbiter_test.sv
module mem_req_arbiter_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int LQD = 4;
  localparam int SQD = 4;
  localparam int RSPD = 4;
  localparam int MEM_LAT = 2;

  logic          clk = 1'b0;
  logic          rst;
  logic          ld_valid, ld_ready, st_valid, st_ready;
  logic [AW-1:0] ld_addr, st_addr;
  logic [DW-1:0] st_data;
  logic          mem_req_valid, mem_req_ready, mem_req_write;
  logic [AW-1:0] mem_req_addr;
  logic [DW-1:0] mem_req_wdata;
  logic          mem_rsp_valid;
  logic [DW-1:0] mem_rsp_data;
  logic          rsp_valid, rsp_ready;
  logic [DW-1:0] rsp_data;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_req_arbiter #(
    .AW(AW), .DW(DW), .LQ_DEPTH(LQD), .SQ_DEPTH(SQD), .RSP_DEPTH(RSPD)
  ) uut (
    .clk(clk), .rst(rst),
    .ld_valid(ld_valid), .ld_ready(ld_ready), .ld_addr(ld_addr),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data)
  );

  int tests = 0, fails = 0, cyc = 0, order_err = 0;
  int ld_acc = 0, st_acc = 0, mem_ld_cnt = 0;
  bit done = 1'b0;

  // driver intent
  logic          d_ld, d_st, d_mrdy, d_rrdy;
  logic [AW-1:0] d_ld_addr, d_st_addr;
  logic [DW-1:0] d_st_data;

  // scoreboard: {write, addr, data}
  logic [AW+DW:0] exp_q[$];
  logic [DW-1:0]  exp_rsp[$];
  logic [DW-1:0]  pend_data[$];
  int             pend_due[$];
  bit             issued_w[$];

  bit             prev_mstall, prev_rstall;
  logic [AW+DW:0] prev_req;
  logic [DW-1:0]  prev_rsp;

  function automatic logic [DW-1:0] mem_val(logic [AW-1:0] a);
    return {a ^ 8'h5A, ~a};
  endfunction

  task automatic check(bit ok, string tag, logic [63:0] act, logic [63:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, expv, cyc);
    end
  endtask

  task automatic tick();
    logic [AW+DW:0] got, want;
    @(negedge clk);
    ld_valid = d_ld; ld_addr = d_ld_addr;
    st_valid = d_st; st_addr = d_st_addr; st_data = d_st_data;
    mem_req_ready = d_mrdy; rsp_ready = d_rrdy;
    if (pend_due.size() > 0 && pend_due[0] <= cyc) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = pend_data.pop_front();
      void'(pend_due.pop_front());
    end else begin
      mem_rsp_valid = 1'b0;
    end
    #1;
    if (prev_mstall)
      check(mem_req_valid && ({mem_req_write, mem_req_addr, mem_req_wdata} == prev_req),
            "R5 request hold", {mem_req_write, mem_req_addr, mem_req_wdata}, prev_req);
    if (prev_rstall)
      check(rsp_valid && (rsp_data == prev_rsp), "R8 response hold", rsp_data, prev_rsp);
    prev_mstall = mem_req_valid && !mem_req_ready;
    prev_req    = {mem_req_write, mem_req_addr, mem_req_wdata};
    prev_rstall = rsp_valid && !rsp_ready;
    prev_rsp    = rsp_data;
    // same-cycle arrivals: store is expected ahead of the load
    if (st_valid && st_ready) begin
      exp_q.push_back({1'b1, st_addr, st_data});
      st_acc++;
    end
    if (ld_valid && ld_ready) begin
      exp_q.push_back({1'b0, ld_addr, {DW{1'b0}}});
      exp_rsp.push_back(mem_val(ld_addr));
      ld_acc++;
    end
    if (mem_req_valid && mem_req_ready) begin
      got = {mem_req_write, mem_req_addr, mem_req_write ? mem_req_wdata : {DW{1'b0}}};
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected request", got, 0);
        order_err++;
      end else begin
        want = exp_q.pop_front();
        if (got != want) order_err++;
        check(got == want, "R2 R3 request order", got, want);
      end
      issued_w.push_back(mem_req_write);
      if (!mem_req_write) begin
        pend_data.push_back(mem_val(mem_req_addr));
        pend_due.push_back(cyc + MEM_LAT);
        mem_ld_cnt++;
      end
    end
    if (rsp_valid && rsp_ready) begin
      if (exp_rsp.size() == 0) check(1'b0, "R8 unexpected response", rsp_data, 0);
      else begin
        want = {{(AW+1){1'b0}}, exp_rsp.pop_front()};
        check(rsp_data == want[DW-1:0], "R8 response data", rsp_data, want);
      end
    end
    cyc++;
  endtask

  task automatic idle_drain(int n);
    d_ld = 0; d_st = 0; d_mrdy = 1; d_rrdy = 1;
    repeat (n) tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n0, m0;
    rst = 1'b1;
    ld_valid = 0; st_valid = 0; ld_addr = 0; st_addr = 0; st_data = 0;
    mem_req_ready = 0; mem_rsp_valid = 0; mem_rsp_data = 0; rsp_ready = 0;
    d_ld = 0; d_st = 0; d_mrdy = 1; d_rrdy = 1;
    d_ld_addr = 0; d_st_addr = 0; d_st_data = 0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    // R1
    check(!mem_req_valid, "R1 mem_req_valid after reset", mem_req_valid, 0);
    check(!rsp_valid, "R1 rsp_valid after reset", rsp_valid, 0);
    check(ld_ready && st_ready, "R1 readys after reset", {ld_ready, st_ready}, 2'b11);

    // R4: same-cycle pair
    d_ld = 1; d_st = 1; d_ld_addr = 8'h11; d_st_addr = 8'h22; d_st_data = 16'hBEEF;
    tick();
    idle_drain(8);
    check(issued_w.size() >= 2 && issued_w[0] == 1'b1 && issued_w[1] == 1'b0,
          "R4 store before same-cycle load", {issued_w[0], issued_w[1]}, 2'b10);

    // R3: arrivals in different cycles while memory is stalled
    d_mrdy = 0;
    d_ld = 1; d_st = 0; d_ld_addr = 8'h31; tick();
    d_ld = 0; d_st = 1; d_st_addr = 8'h32; d_st_data = 16'h1234; tick();
    d_ld = 1; d_st = 1; d_ld_addr = 8'h33; d_st_addr = 8'h34; d_st_data = 16'h5678; tick();
    d_ld = 0; d_st = 0; tick(); tick();
    idle_drain(12);
    check(issued_w.size() == 6 && {issued_w[2], issued_w[3], issued_w[4], issued_w[5]} == 4'b0110,
          "R3 R4 kind sequence", {issued_w[2], issued_w[3], issued_w[4], issued_w[5]}, 4'b0110);

    // R6: load fill with memory stalled
    n0 = ld_acc;
    d_mrdy = 0; d_ld = 1; d_st = 0;
    for (int i = 0; i < 12; i++) begin d_ld_addr = 8'(8'h40 + i); tick(); end
    check(ld_acc - n0 == LQD + 1, "R6 loads accepted while stalled", ld_acc - n0, LQD + 1);
    check(!ld_ready, "R6 ld_ready low when full", ld_ready, 0);
    check(st_ready, "R7 st_ready unaffected by load fill", st_ready, 1);
    idle_drain(30);

    // R7: store fill with memory stalled
    n0 = st_acc;
    d_mrdy = 0; d_st = 1; d_ld = 0;
    for (int i = 0; i < 12; i++) begin
      d_st_addr = 8'(8'h60 + i); d_st_data = 16'(16'hA000 + i); tick();
    end
    check(st_acc - n0 == SQD + 1, "R7 stores accepted while stalled", st_acc - n0, SQD + 1);
    check(!st_ready, "R7 st_ready low when full", st_ready, 0);
    idle_drain(30);

    // R9: response consumer stalled
    n0 = ld_acc; m0 = mem_ld_cnt;
    d_mrdy = 1; d_rrdy = 0; d_ld = 1; d_st = 0;
    for (int i = 0; i < 20; i++) begin d_ld_addr = 8'(8'h80 + i); tick(); end
    check(mem_ld_cnt - m0 == RSPD, "R9 loads sent with responses blocked", mem_ld_cnt - m0, RSPD);
    check(ld_acc - n0 == RSPD + LQD, "R9 loads accepted with responses blocked", ld_acc - n0, RSPD + LQD);
    idle_drain(40);

    // R10 and general sweep: memory-ready and response-ready duty grid
    order_err = 0;
    for (int md = 0; md < 4; md++) begin
      for (int rd = 0; rd < 4; rd++) begin
        for (int k = 0; k < 300; k++) begin
          d_ld = 1'($urandom); d_st = 1'($urandom);
          d_ld_addr = 8'($urandom); d_st_addr = 8'($urandom); d_st_data = 16'($urandom);
          d_mrdy = (($urandom % 4) >= md);
          d_rrdy = (($urandom % 4) >= rd);
          tick();
        end
      end
    end
    idle_drain(60);
    check(order_err == 0, "R10 order across stamp wraparound", order_err, 0);
    check((ld_acc + st_acc) > 256, "R10 enough traffic to wrap stamps", ld_acc + st_acc, 257);
    check(exp_q.size() == 0, "R2 every request forwarded", exp_q.size(), 0);
    check(exp_rsp.size() == 0, "R8 every response returned", exp_rsp.size(), 0);
    check(!mem_req_valid && !rsp_valid, "R5 idle after drain", {mem_req_valid, rsp_valid}, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule